// File: doc/BRIEF.md
# Readout Event Generator with Fault Injection

The block produces a byte-wide stream of detector readout events, one event per accepted trigger, toward a line encoder. Every event normally opens with a two-byte header that carries the event number, continues with a payload, and closes with a two-byte trailer that carries the payload length. The payload is either a counting pattern of programmable length or a replay of the first entries of a small on-chip table of hit records, which are loaded through a write port.

Triggers are accepted into a four-entry queue, so they may arrive while an earlier event is still going out. A set of arming slots lets a test deliberately damage one chosen event: flip one bit of one byte, drop its header, drop its trailer, hold it back by a programmable number of cycles, or corrupt its event number. This exercises the error handling of a downstream receiver. Each slot holds a target event number, fires once on the trigger that receives that number, and then disarms itself. The output follows a valid/ready handshake.

Top module: `evt_gen`

## Requirements
- R1: An event whose header and trailer are kept is emitted as 8'hA5, the event number, the payload bytes, 8'h5A and then the payload length. A one-cycle idle gap separates consecutive events.
- R2: With replay_i low, the payload has fixed_len_i bytes and byte i equals (event number + i) mod 256. A length of 0 gives header and trailer only.
- R3: With replay_i high, the payload is table entries 0 to n-1, where n is tbl_len_i clamped to the table depth. Entries are written through tbl_we_i, tbl_addr_i and tbl_data_i.
- R4: The event counter resets to 0 and advances by one on every accepted trigger, including triggers whose header is dropped. Triggers on consecutive cycles each produce an event, in order.
- R5: Accepted triggers wait in a queue of depth 4. A trigger that arrives while the queue is full is discarded without advancing the counter, and it sets overflow_o, which stays set until reset.
- R6: Fault kind 0 (bit flip) inverts bit flip_bit_i of the byte at position flip_pos_i among the bytes the event actually emits, counted from 0. A position past the end of the event has no effect.
- R7: Fault kind 1 drops the two header bytes of the event.
- R8: Fault kind 2 drops the two trailer bytes of the event.
- R9: Fault kind 3 delays the first byte of the event by delay_i cycles (0 to 65535) relative to an undisturbed event.
- R10: Fault kind 4 replaces the event-number header byte with its bitwise inverse.
- R11: A write with arm_we_i sets slot arm_kind_i with target arm_evn_i and raises armed_o[arm_kind_i]. The slot fires only on the accepted trigger that is given that event number, and then clears its armed_o bit. Kind codes 5 to 7 are ignored.
- R12: While valid_o is high and ready_i is low, data_o and valid_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger, one per high cycle |
| replay_i | input | 1 | Payload source: 0 counting pattern, 1 table replay |
| fixed_len_i | input | 8 | Payload length in pattern mode |
| tbl_len_i | input | 4 | Number of table entries replayed |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | 3 | Table write address |
| tbl_data_i | input | 8 | Table write data |
| arm_we_i | input | 1 | Arm strobe for one fault slot |
| arm_kind_i | input | 3 | Fault kind to arm (0 to 4) |
| arm_evn_i | input | 8 | Target event number |
| flip_pos_i | input | 8 | Byte position for the bit flip |
| flip_bit_i | input | 3 | Bit index for the bit flip |
| delay_i | input | 16 | Hold-back cycles for a delayed event |
| ready_i | input | 1 | Downstream ready |
| data_o | output | 8 | Stream byte |
| valid_o | output | 1 | Stream byte valid |
| overflow_o | output | 1 | Sticky trigger-queue overflow flag |
| armed_o | output | 5 | Armed state of each fault slot |

## Verification
A trigger can be accepted into the queue in the same cycle that the framer pops the queue to start the previous event. The bench provokes this by firing triggers on four consecutive cycles while ready_i toggles in a fixed pattern, then checks that the captured stream contains four complete events with consecutive event numbers in order. Two faults that act on one event at once, a dropped header together with a bit flip, are also combined. That case is judged by whether the flip lands on the first payload byte, since the flip position counts only bytes that are actually emitted.

// File: rtl/evt_gen_pkg.sv
package evt_gen_pkg;
  localparam int DW   = 8;
  localparam int NFLT = 5;

  localparam int F_FLIP   = 0;
  localparam int F_NOHDR  = 1;
  localparam int F_NOTRL  = 2;
  localparam int F_DELAY  = 3;
  localparam int F_EVNERR = 4;

  typedef logic [DW-1:0] byte_t;

  localparam byte_t HDR_MARK = 8'hA5;
  localparam byte_t TRL_MARK = 8'h5A;

  typedef struct packed {
    logic [NFLT-1:0] flt;
    byte_t           evn;
  } trig_ent_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_HDR0, ST_HDR1, ST_PAY, ST_TRL0, ST_TRL1
  } fr_st_e;
endpackage

// File: rtl/evt_trig_fifo.sv
module evt_trig_fifo #(
  parameter int W     = 13,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/evt_inject_arm.sv
module evt_inject_arm
  import evt_gen_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_we_i,
  input  logic [2:0]      arm_kind_i,
  input  byte_t           arm_evn_i,
  input  logic            acc_i,
  input  byte_t           evn_i,
  output logic [NFLT-1:0] armed_o,
  output logic [NFLT-1:0] fire_o
);
  for (genvar k = 0; k < NFLT; k++) begin : g_slot
    logic  armed_q;
    byte_t tgt_q;
    logic  hit;

    assign hit       = arm_we_i && (arm_kind_i == 3'(k));
    assign fire_o[k] = acc_i && armed_q && (tgt_q == evn_i);
    assign armed_o[k] = armed_q;

    // a fresh arm write wins over a firing in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        armed_q <= 1'b0;
        tgt_q   <= '0;
      end else if (hit) begin
        armed_q <= 1'b1;
        tgt_q   <= arm_evn_i;
      end else if (fire_o[k]) begin
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/evt_framer.sv
module evt_framer
  import evt_gen_pkg::*;
#(
  parameter int TBL_DEPTH = 8,
  parameter int LEN_W     = 8,
  parameter int DLY_W     = 16,
  localparam int TBL_AW   = $clog2(TBL_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ent_vld_i,
  input  trig_ent_t        ent_i,
  output logic             pop_o,
  input  logic             replay_i,
  input  logic [LEN_W-1:0] fixed_len_i,
  input  logic [TBL_AW:0]  tbl_len_i,
  input  logic             tbl_we_i,
  input  logic [TBL_AW-1:0] tbl_addr_i,
  input  byte_t            tbl_data_i,
  input  logic [LEN_W-1:0] flip_pos_i,
  input  logic [2:0]       flip_bit_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             ready_i,
  output byte_t            data_o,
  output logic             valid_o
);
  localparam logic [TBL_AW:0] TBL_MAX = (TBL_AW + 1)'(TBL_DEPTH);

  byte_t            tbl_q [TBL_DEPTH];
  fr_st_e           st_q;
  trig_ent_t        cur_q;
  logic [LEN_W-1:0] len_q, idx_q, len_in;
  logic [LEN_W:0]   pos_q;
  logic [DLY_W-1:0] dly_q;
  logic             rep_q, fire;
  byte_t            raw, flip_mask;

  function automatic fr_st_e tail_st(input logic notrl);
    return notrl ? ST_IDLE : ST_TRL0;
  endfunction

  function automatic fr_st_e body_st(input logic [LEN_W-1:0] l, input logic notrl);
    return (l != '0) ? ST_PAY : tail_st(notrl);
  endfunction

  function automatic fr_st_e head_st(input logic [NFLT-1:0] f, input logic [LEN_W-1:0] l);
    return f[F_NOHDR] ? body_st(l, f[F_NOTRL]) : ST_HDR0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TBL_DEPTH; i++) tbl_q[i] <= '0;
    end else if (tbl_we_i) begin
      tbl_q[tbl_addr_i] <= tbl_data_i;
    end
  end

  assign len_in = replay_i ? LEN_W'((tbl_len_i > TBL_MAX) ? TBL_MAX : tbl_len_i)
                           : fixed_len_i;
  assign pop_o   = (st_q == ST_IDLE) && ent_vld_i;
  assign valid_o = (st_q != ST_IDLE) && (st_q != ST_WAIT);
  assign fire    = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
      len_q <= '0;
      idx_q <= '0;
      pos_q <= '0;
      dly_q <= '0;
      rep_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (ent_vld_i) begin
          cur_q <= ent_i;
          len_q <= len_in;
          rep_q <= replay_i;
          idx_q <= '0;
          pos_q <= '0;
          if (ent_i.flt[F_DELAY] && delay_i != '0) begin
            dly_q <= delay_i;
            st_q  <= ST_WAIT;
          end else begin
            st_q <= head_st(ent_i.flt, len_in);
          end
        end
        ST_WAIT: begin
          if (dly_q == DLY_W'(1)) st_q <= head_st(cur_q.flt, len_q);
          else                    dly_q <= dly_q - 1'b1;
        end
        default: if (fire) begin
          pos_q <= pos_q + 1'b1;
          case (st_q)
            ST_HDR0: st_q <= ST_HDR1;
            ST_HDR1: st_q <= body_st(len_q, cur_q.flt[F_NOTRL]);
            ST_PAY: begin
              idx_q <= idx_q + 1'b1;
              if (idx_q == len_q - 1'b1) st_q <= tail_st(cur_q.flt[F_NOTRL]);
            end
            ST_TRL0: st_q <= ST_TRL1;
            default: st_q <= ST_IDLE;
          endcase
        end
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_HDR0: raw = HDR_MARK;
      ST_HDR1: raw = cur_q.flt[F_EVNERR] ? ~cur_q.evn : cur_q.evn;
      ST_PAY:  raw = rep_q ? tbl_q[idx_q[TBL_AW-1:0]] : byte_t'(cur_q.evn + byte_t'(idx_q));
      ST_TRL0: raw = TRL_MARK;
      ST_TRL1: raw = byte_t'(len_q);
      default: raw = '0;
    endcase
  end

  assign flip_mask = (cur_q.flt[F_FLIP] && pos_q == {1'b0, flip_pos_i})
                     ? (byte_t'(1) << flip_bit_i) : '0;
  assign data_o = raw ^ flip_mask;
endmodule

// File: rtl/evt_gen.sv
module evt_gen
  import evt_gen_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int TBL_DEPTH  = 8,
  parameter int LEN_W      = 8,
  parameter int DLY_W      = 16,
  localparam int TBL_AW    = $clog2(TBL_DEPTH),
  localparam int CW        = $clog2(FIFO_DEPTH + 1),
  localparam int EW        = $bits(trig_ent_t)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              replay_i,
  input  logic [LEN_W-1:0]  fixed_len_i,
  input  logic [TBL_AW:0]   tbl_len_i,
  input  logic              tbl_we_i,
  input  logic [TBL_AW-1:0] tbl_addr_i,
  input  logic [DW-1:0]     tbl_data_i,
  input  logic              arm_we_i,
  input  logic [2:0]        arm_kind_i,
  input  logic [DW-1:0]     arm_evn_i,
  input  logic [LEN_W-1:0]  flip_pos_i,
  input  logic [2:0]        flip_bit_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic              ready_i,
  output logic [DW-1:0]     data_o,
  output logic              valid_o,
  output logic              overflow_o,
  output logic [NFLT-1:0]   armed_o
);
  logic            fifo_full, fifo_empty, pop, acc, ovf_q;
  logic [CW-1:0]   fifo_cnt;
  logic [EW-1:0]   fifo_rd;
  logic [NFLT-1:0] fire;
  byte_t           evn_q;
  trig_ent_t       push_ent, head_ent;

  assign acc      = trig_i && !fifo_full;
  assign push_ent = '{flt: fire, evn: evn_q};
  assign head_ent = trig_ent_t'(fifo_rd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evn_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (acc)                  evn_q <= evn_q + 1'b1;
      if (trig_i && fifo_full)  ovf_q <= 1'b1;
    end
  end
  assign overflow_o = ovf_q;

  evt_inject_arm u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_we_i   (arm_we_i),
    .arm_kind_i (arm_kind_i),
    .arm_evn_i  (arm_evn_i),
    .acc_i      (acc),
    .evn_i      (evn_q),
    .armed_o    (armed_o),
    .fire_o     (fire)
  );

  evt_trig_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (acc),
    .wdata_i (push_ent),
    .pop_i   (pop),
    .rdata_o (fifo_rd),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .cnt_o   (fifo_cnt)
  );

  evt_framer #(.TBL_DEPTH(TBL_DEPTH), .LEN_W(LEN_W), .DLY_W(DLY_W)) u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ent_vld_i   (!fifo_empty),
    .ent_i       (head_ent),
    .pop_o       (pop),
    .replay_i    (replay_i),
    .fixed_len_i (fixed_len_i),
    .tbl_len_i   (tbl_len_i),
    .tbl_we_i    (tbl_we_i),
    .tbl_addr_i  (tbl_addr_i),
    .tbl_data_i  (tbl_data_i),
    .flip_pos_i  (flip_pos_i),
    .flip_bit_i  (flip_bit_i),
    .delay_i     (delay_i),
    .ready_i     (ready_i),
    .data_o      (data_o),
    .valid_o     (valid_o)
  );
endmodule

// File: rtl/evt_gen_chk.sv
module evt_gen_chk #(
  parameter int FIFO_DEPTH = 4,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          trig_i,
  input logic          ready_i,
  input logic          valid_o,
  input logic [7:0]    data_o,
  input logic          overflow_o,
  input logic [4:0]    armed_o,
  input logic [CW-1:0] fifo_cnt_i,
  input logic          fifo_full_i
);
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));

  assert_sticky_ovf_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  assert_ovf_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(trig_i && fifo_full_i));

  assert_queue_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= CW'(FIFO_DEPTH));

  assert_disarm_on_trig_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(armed_o) & ~armed_o)) |-> $past(trig_i));
endmodule

bind evt_gen evt_gen_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_i      (trig_i),
  .ready_i     (ready_i),
  .valid_o     (valid_o),
  .data_o      (data_o),
  .overflow_o  (overflow_o),
  .armed_o     (armed_o),
  .fifo_cnt_i  (fifo_cnt),
  .fifo_full_i (fifo_full)
);

// File: tb/evt_gen_tb.sv
module evt_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        replay = 1'b0;
  logic [7:0]  fixed_len = '0;
  logic [3:0]  tbl_len = '0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_addr = '0;
  logic [7:0]  tbl_data = '0;
  logic        arm_we = 1'b0;
  logic [2:0]  arm_kind = '0;
  logic [7:0]  arm_evn = '0;
  logic [7:0]  flip_pos = '0;
  logic [2:0]  flip_bit = '0;
  logic [15:0] delay = '0;
  logic        ready = 1'b1;
  logic [7:0]  data_o;
  logic        valid_o, overflow_o;
  logic [4:0]  armed_o;

  int n_chk = 0, n_fail = 0, rmode = 0, cyc = 0, next_evn = 0;
  bit done = 0;
  logic [7:0] exp_q[$], got_q[$];

  evt_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .replay_i(replay),
    .fixed_len_i(fixed_len), .tbl_len_i(tbl_len), .tbl_we_i(tbl_we),
    .tbl_addr_i(tbl_addr), .tbl_data_i(tbl_data), .arm_we_i(arm_we),
    .arm_kind_i(arm_kind), .arm_evn_i(arm_evn), .flip_pos_i(flip_pos),
    .flip_bit_i(flip_bit), .delay_i(delay), .ready_i(ready),
    .data_o(data_o), .valid_o(valid_o), .overflow_o(overflow_o), .armed_o(armed_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    #1;
    ready = (rmode == 0) ? 1'b1 : (rmode == 2) ? 1'b0 : ((cyc % 3) != 0);
  end

  always @(negedge clk) if (rst_n && valid_o && ready) got_q.push_back(data_o);

  function automatic logic [7:0] tbl_val(input int i);
    return 8'(8'h40 + 29 * i);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_evt(input int evn, input int len, input bit rep,
                           input logic [4:0] f, input int fpos, input int fbit);
    logic [7:0] b[$];
    if (!f[1]) begin
      b.push_back(8'hA5);
      b.push_back(f[4] ? ~8'(evn) : 8'(evn));
    end
    for (int i = 0; i < len; i++) b.push_back(rep ? tbl_val(i) : 8'(evn + i));
    if (!f[2]) begin
      b.push_back(8'h5A);
      b.push_back(8'(len));
    end
    if (f[0] && fpos < b.size()) b[fpos] = b[fpos] ^ 8'(1 << fbit);
    foreach (b[i]) exp_q.push_back(b[i]);
  endtask

  task automatic cmp(input string tag);
    int bad = -1;
    int n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    chk(got_q.size() == exp_q.size(), {tag, " length"}, got_q.size(), exp_q.size());
    for (int i = 0; i < n; i++) if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
    chk(bad < 0, {tag, " bytes"}, (bad < 0) ? 0 : int'(got_q[bad]),
        (bad < 0) ? 0 : int'(exp_q[bad]));
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic pulse();
    @(posedge clk); #1 trig = 1'b1;
    @(posedge clk); #1 trig = 1'b0;
  endtask

  task automatic burst(input int n);
    @(posedge clk); #1 trig = 1'b1;
    repeat (n) @(posedge clk);
    #1 trig = 1'b0;
  endtask

  task automatic arm(input int kind, input int evn);
    @(posedge clk); #1 arm_we = 1'b1; arm_kind = 3'(kind); arm_evn = 8'(evn);
    @(posedge clk); #1 arm_we = 1'b0;
  endtask

  task automatic drain();
    int quiet = 0;
    while (quiet < 16) begin
      @(negedge clk);
      quiet = valid_o ? 0 : quiet + 1;
    end
  endtask

  task automatic trig_lat(output int lat);
    @(posedge clk); #1 trig = 1'b1;
    @(posedge clk); #1 trig = 1'b0;
    lat = 0;
    while (!valid_o) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int l0, ld;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0, "R1 reset valid", valid_o, 0);
    chk(overflow_o == 1'b0, "R5 reset overflow", overflow_o, 0);
    chk(armed_o == 5'b0, "R11 reset armed", armed_o, 0);

    // R1 R2: pattern payload, lengths 0..6
    for (int l = 0; l < 7; l++) begin
      fixed_len = 8'(l);
      pulse();
      model_evt(next_evn, l, 0, 5'b0, 0, 0);
      next_evn++;
      drain();
    end
    cmp("R2 pattern sweep");

    // R3: table replay, lengths 0..8 plus clamp
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1 tbl_we = 1'b1; tbl_addr = 3'(i); tbl_data = tbl_val(i);
    end
    @(posedge clk); #1 tbl_we = 1'b0;
    replay = 1'b1;
    for (int n = 0; n < 10; n++) begin
      tbl_len = (n == 9) ? 4'd13 : 4'(n);
      pulse();
      model_evt(next_evn, (n == 9) ? 8 : n, 1, 5'b0, 0, 0);
      next_evn++;
      drain();
    end
    cmp("R3 replay sweep");
    replay = 1'b0;

    // R7 R8 R10 with R4 numbering across suppressed headers
    fixed_len = 8'd3;
    for (int k = 1; k <= 4; k++) begin
      string tag;
      if (k == 3) continue;
      tag = (k == 1) ? "R7 header drop" : (k == 2) ? "R8 trailer drop" : "R10 number error";
      arm(k, next_evn + 1);
      chk(armed_o == 5'(1 << k), "R11 armed", armed_o, 1 << k);
      for (int j = 0; j < 3; j++) begin
        pulse();
        model_evt(next_evn, 3, 0, (j == 1) ? 5'(1 << k) : 5'b0, 0, 0);
        next_evn++;
      end
      drain();
      cmp(tag);
      chk(armed_o == 5'b0, "R11 self clear", armed_o, 0);
    end

    // R6: bit flip sweep over emitted positions
    for (int p = 0; p < 6; p++) begin
      for (int bi = 0; bi < 3; bi++) begin
        int pos = (p == 5) ? 9 : (p == 3) ? 4 : (p == 4) ? 6 : p;
        int bt = (bi == 0) ? 0 : (bi == 1) ? 3 : 7;
        flip_pos = 8'(pos);
        flip_bit = 3'(bt);
        arm(0, next_evn);
        pulse();
        model_evt(next_evn, 3, 0, 5'b00001, pos, bt);
        next_evn++;
        drain();
      end
    end
    cmp("R6 bit flip sweep");

    // R6 R7 combined: flip counts only emitted bytes
    flip_pos = 8'd0;
    flip_bit = 3'd5;
    arm(1, next_evn);
    arm(0, next_evn);
    pulse();
    model_evt(next_evn, 3, 0, 5'b00011, 0, 5);
    next_evn++;
    drain();
    cmp("R6 flip with R7 drop");

    // R11: unused kind code ignored
    arm(5, next_evn);
    chk(armed_o == 5'b0, "R11 kind 5 ignored", armed_o, 0);
    pulse();
    model_evt(next_evn, 3, 0, 5'b0, 0, 0);
    next_evn++;
    drain();
    cmp("R11 kind 5 stream");

    // R11: armed for a later number, earlier events untouched
    arm(2, next_evn + 2);
    pulse();
    model_evt(next_evn, 3, 0, 5'b0, 0, 0);
    next_evn++;
    drain();
    chk(armed_o == 5'b00100, "R11 waits for target", armed_o, 4);
    pulse();
    model_evt(next_evn, 3, 0, 5'b0, 0, 0);
    next_evn++;
    pulse();
    model_evt(next_evn, 3, 0, 5'b00100, 0, 0);
    next_evn++;
    drain();
    cmp("R11 target match");

    // R9: delayed event latency
    trig_lat(l0);
    model_evt(next_evn, 3, 0, 5'b0, 0, 0);
    next_evn++;
    drain();
    for (int di = 0; di < 4; di++) begin
      int d = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 7 : 300;
      delay = 16'(d);
      arm(3, next_evn);
      trig_lat(ld);
      chk(ld == l0 + d, "R9 delay latency", ld, l0 + d);
      model_evt(next_evn, 3, 0, 5'b01000, 0, 0);
      next_evn++;
      drain();
    end
    cmp("R9 delayed stream");

    // R4 R12: back-to-back triggers with toggling ready
    rmode = 1;
    fixed_len = 8'd2;
    burst(4);
    for (int j = 0; j < 4; j++) begin
      model_evt(next_evn, 2, 0, 5'b0, 0, 0);
      next_evn++;
    end
    drain();
    cmp("R4 back-to-back R12 stall");
    replay = 1'b1;
    tbl_len = 4'd5;
    burst(3);
    for (int j = 0; j < 3; j++) begin
      model_evt(next_evn, 5, 1, 5'b0, 0, 0);
      next_evn++;
    end
    drain();
    cmp("R12 replay under stall");
    replay = 1'b0;

    // R5: overflow with output blocked
    rmode = 2;
    fixed_len = 8'd1;
    for (int j = 0; j < 5; j++) begin
      pulse();
      repeat (2) @(posedge clk);
    end
    @(negedge clk);
    chk(overflow_o == 1'b0, "R5 no overflow at depth", overflow_o, 0);
    pulse();
    @(negedge clk);
    chk(overflow_o == 1'b1, "R5 overflow set", overflow_o, 1);
    for (int j = 0; j < 5; j++) begin
      model_evt(next_evn, 1, 0, 5'b0, 0, 0);
      next_evn++;
    end
    rmode = 0;
    drain();
    cmp("R5 queued events");
    pulse();
    model_evt(next_evn, 1, 0, 5'b0, 0, 0);
    next_evn++;
    drain();
    cmp("R5 R4 counter after drop");
    chk(overflow_o == 1'b1, "R5 overflow sticky", overflow_o, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule